// File: doc/BRIEF.md
# Vsync-Latched Shadow Register Bank

This block keeps the configuration of several display windows in two copies. Software writes a working copy through a simple write port. The display pipeline sees only the active copy. A window's active copy changes only on a vertical-sync strobe, and only after software has asked for an update. Each window can be protected. While it is protected, its active copy keeps its old contents even at vertical sync. Software can therefore rewrite several fields of one window and have all of them reach the pipeline together.

Each window has `NUM_SLOT` data slots of `DATA_W` bits. Slot 0 is the window's control word, and bit 0 of that word enables the window. The last slot holds the color key. Window 0 has no color key, so that slot is absent for window 0. A small global region holds the per-window protect mask and the update request bit. Both copies of every slot can be read back, and so can both global registers.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After reset, every working and active slot reads 0, the protect mask reads 0, the update bit reads 0 and `win_en` is 0.
- R2: A write with `wr_glb`=0 stores `wr_data` in the working slot (`wr_win`,`wr_slot`). It can be read back in the next cycle. The active copy does not change.
- R3: A `vsync` pulse with no pending update request leaves every active slot unchanged.
- R4: Writing global slot 1 with data bit 0 set marks every window pending. At the next `vsync`, each pending window that is not protected copies all of its working slots into its active slot set. The update bit (global slot 1, bit 0) reads 1 while any window is pending and returns to 0 once every window has loaded.
- R5: Global slot 0 holds the protect mask, one bit per window, where bit w protects window w. A protected window is not loaded at `vsync` and stays pending.
- R6: Once a window's protect bit is cleared, the change still pending for it is loaded at the first following `vsync`.
- R7: `win_en[w]` equals bit 0 of window w's active slot 0. Clearing the enable bit in the working copy does not change `win_en` until a load at `vsync`.
- R8: For window 0, slot `NUM_SLOT`-1 (the color key) ignores writes and reads 0 in both copies.
- R9: With `rd_glb`=0, `rd_data` returns the working copy when `rd_act`=0 and the active copy when `rd_act`=1, both combinationally. With `rd_glb`=1, slot 0 returns the protect mask, slot 1 returns the update bit, and any other slot returns 0.
- R10: A load at `vsync` takes the working values from before a write in the same cycle. An update request in the same cycle as `vsync` takes effect at the next `vsync`.
- R11: `act_cfg` holds the active slot (w,s) at bits [(w*NUM_SLOT+s)*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical-sync strobe, one cycle |
| wr_en | input | 1 | Write strobe |
| wr_glb | input | 1 | Write targets the global region |
| wr_win | input | WIN_W | Window index of a write |
| wr_slot | input | SLOT_W | Slot index of a write |
| wr_data | input | DATA_W | Write data |
| rd_glb | input | 1 | Read from the global region |
| rd_act | input | 1 | Read the active copy (1) or the working copy (0) |
| rd_win | input | WIN_W | Window index of a read |
| rd_slot | input | SLOT_W | Slot index of a read |
| rd_data | output | DATA_W | Read data, combinational |
| act_cfg | output | NUM_WIN*NUM_SLOT*DATA_W | All active slots, flattened |
| win_en | output | NUM_WIN | Per-window enable taken from the active copy |

## Verification
Four properties are checked on every cycle:
- An active copy holds whenever there is no vsync, the window is protected or nothing is pending.
- A load copies exactly the previous working values.
- A protected window keeps its pending flag.
- Window 0's key slot stays zero.

The bench's scenarios show the rest, with a model computed alongside the stimulus:
- the end-to-end protect-then-release sequence;
- the update bit clearing only after the last window loads;
- how a write and a load interact in the same cycle;
- readback through both views.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
    localparam int GLB_SLOT_PROT = 0;
    localparam int GLB_SLOT_UPD  = 1;
endpackage

// File: rtl/shadow_glb_ctrl.sv
module shadow_glb_ctrl
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 16,
    parameter int SLOT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               wr_glb_i,
    input  logic [SLOT_W-1:0]  wr_slot_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [NUM_WIN-1:0] prot_o,
    output logic               trig_o
);
    typedef struct packed {
        logic [NUM_WIN-1:0] prot;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     prot_wr;

    always_comb begin
        st_d    = st_q;
        prot_wr = wr_en_i && wr_glb_i && (int'(wr_slot_i) == GLB_SLOT_PROT);
        trig_o  = wr_en_i && wr_glb_i && (int'(wr_slot_i) == GLB_SLOT_UPD) && wr_data_i[0];
        if (prot_wr) st_d.prot = wr_data_i[NUM_WIN-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot_o = st_q.prot;

    // R5: protect mask moves only on a write to its global slot
    assert_prot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_glb_i && int'(wr_slot_i) == GLB_SLOT_PROT) |=> $stable(prot_o));
endmodule

// File: rtl/shadow_win_slice.sv
module shadow_win_slice #(
    parameter int WIN_IDX  = 0,
    parameter int NUM_SLOT = 8,
    parameter int DATA_W   = 16,
    parameter int SLOT_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             vsync_i,
    input  logic                             wr_en_i,
    input  logic [SLOT_W-1:0]                wr_slot_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    input  logic                             trig_i,
    input  logic                             prot_i,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]  work_o,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]  act_o,
    output logic                             pend_o
);
    localparam int KEY_SLOT = NUM_SLOT - 1;
    localparam bit HAS_KEY  = (WIN_IDX != 0);

    typedef logic [NUM_SLOT-1:0][DATA_W-1:0] bank_t;
    typedef struct packed {
        bank_t work;
        bank_t act;
        logic  pend;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      load;
    logic      wr_ok;

    always_comb begin
        st_d  = st_q;
        load  = vsync_i && st_q.pend && !prot_i;
        wr_ok = wr_en_i && (HAS_KEY || int'(wr_slot_i) != KEY_SLOT)
                && int'(wr_slot_i) < NUM_SLOT;
        if (load) st_d.act = st_q.work;
        st_d.pend = (st_q.pend && !load) || trig_i;
        if (wr_ok) st_d.work[wr_slot_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign work_o = st_q.work;
    assign act_o  = st_q.act;
    assign pend_o = st_q.pend;

    // R3, R5: active copy holds unless an unprotected pending load fires
    assert_act_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_i || prot_i || !pend_o) |=> $stable(act_o));
    // R4, R10: a load copies the pre-edge working values
    assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && pend_o && !prot_i) |=> (act_o == $past(work_o)));
    // R5: a protected pending window stays pending
    assert_pend_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_i && pend_o) |=> pend_o);

    if (!HAS_KEY) begin : g_nokey
        // R8: window without colour key keeps that slot at zero
        assert_nokey_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (work_o[KEY_SLOT] == '0) && (act_o[KEY_SLOT] == '0));
    end
endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int NUM_SLOT = 8,
    parameter int DATA_W   = 16,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int SLOT_W  = (NUM_SLOT > 2) ? $clog2(NUM_SLOT) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               vsync,
    input  logic                               wr_en,
    input  logic                               wr_glb,
    input  logic [WIN_W-1:0]                   wr_win,
    input  logic [SLOT_W-1:0]                  wr_slot,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               rd_glb,
    input  logic                               rd_act,
    input  logic [WIN_W-1:0]                   rd_win,
    input  logic [SLOT_W-1:0]                  rd_slot,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_WIN*NUM_SLOT*DATA_W-1:0] act_cfg,
    output logic [NUM_WIN-1:0]                 win_en
);
    logic [NUM_WIN-1:0][NUM_SLOT-1:0][DATA_W-1:0] work_all, act_all;
    logic [NUM_WIN-1:0] prot, pend;
    logic               trig;

    shadow_glb_ctrl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_glb_i(wr_glb),
        .wr_slot_i(wr_slot), .wr_data_i(wr_data), .prot_o(prot), .trig_o(trig)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic wr_sel;
        assign wr_sel = wr_en && !wr_glb && (wr_win == WIN_W'(w));
        shadow_win_slice #(.WIN_IDX(w), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W),
                           .SLOT_W(SLOT_W)) u_slice (
            .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .wr_en_i(wr_sel),
            .wr_slot_i(wr_slot), .wr_data_i(wr_data), .trig_i(trig),
            .prot_i(prot[w]), .work_o(work_all[w]), .act_o(act_all[w]),
            .pend_o(pend[w])
        );
        assign win_en[w] = act_all[w][0][0];
    end

    assign act_cfg = act_all;

    always_comb begin
        rd_data = '0;
        if (rd_glb) begin
            if (int'(rd_slot) == GLB_SLOT_PROT)     rd_data = DATA_W'(prot);
            else if (int'(rd_slot) == GLB_SLOT_UPD) rd_data = DATA_W'(|pend);
        end else if (int'(rd_win) < NUM_WIN && int'(rd_slot) < NUM_SLOT) begin
            rd_data = rd_act ? act_all[rd_win][rd_slot] : work_all[rd_win][rd_slot];
        end
    end

    // R7: enables change only on a vsync edge
    assert_en_vsync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(win_en));
endmodule

// File: tb/tb_shadow_cfg_bank.sv
module tb_shadow_cfg_bank;
    localparam int NW = 4, NS = 8, DW = 16;

    logic clk = 0, rst_n = 0, vsync = 0, wr_en = 0, wr_glb = 0;
    logic [1:0] wr_win = 0, rd_win = 0;
    logic [2:0] wr_slot = 0, rd_slot = 0;
    logic [DW-1:0] wr_data = 0, rd_data;
    logic rd_glb = 0, rd_act = 0;
    logic [NW*NS*DW-1:0] act_cfg;
    logic [NW-1:0] win_en;

    shadow_cfg_bank #(.NUM_WIN(NW), .NUM_SLOT(NS), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_glb(wr_glb),
        .wr_win(wr_win), .wr_slot(wr_slot), .wr_data(wr_data), .rd_glb(rd_glb),
        .rd_act(rd_act), .rd_win(rd_win), .rd_slot(rd_slot), .rd_data(rd_data),
        .act_cfg(act_cfg), .win_en(win_en)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] m_work [NW][NS];
    logic [DW-1:0] m_act  [NW][NS];
    logic [NW-1:0] m_prot = 0, m_pend = 0;

    function automatic logic [DW-1:0] pat(int w, int s, int g);
        return DW'(g * 4099 + w * 257 + s * 17 + g + w);
    endfunction

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one clock of stimulus; the model follows the requirements
    task automatic tick(logic we, logic glb, int win, int slot, logic [DW-1:0] d, logic vs);
        logic [NW-1:0] ld;
        logic trg;
        @(negedge clk);
        wr_en = we; wr_glb = glb; wr_win = win[1:0]; wr_slot = slot[2:0];
        wr_data = d; vsync = vs;
        ld  = vs ? (m_pend & ~m_prot) : '0;
        trg = we && glb && slot == 1 && d[0];
        for (int w = 0; w < NW; w++)
            if (ld[w]) for (int s = 0; s < NS; s++) m_act[w][s] = m_work[w][s];
        m_pend = (m_pend & ~ld) | {NW{trg}};
        if (we && !glb && !(win == 0 && slot == NS - 1)) m_work[win][slot] = d;
        if (we && glb && slot == 0) m_prot = d[NW-1:0];
        @(posedge clk); #1;
        wr_en = 0; vsync = 0; wr_glb = 0;
    endtask

    task automatic check_all(string tag);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                string t;
                t = (w == 0 && s == NS - 1) ? "R8" : tag;
                rd_glb = 0; rd_win = w[1:0]; rd_slot = s[2:0];
                rd_act = 0; #1; check($sformatf("%s work w%0d s%0d", t, w, s), rd_data, m_work[w][s]);
                rd_act = 1; #1; check($sformatf("%s act w%0d s%0d", t, w, s), rd_data, m_act[w][s]);
                check($sformatf("R11 act_cfg w%0d s%0d", w, s),
                      act_cfg[(w*NS+s)*DW +: DW], m_act[w][s]);
            end
        for (int w = 0; w < NW; w++)
            check($sformatf("R7 win_en w%0d", w), DW'(win_en[w]), DW'(m_act[w][0][0]));
        rd_glb = 1; rd_slot = 0; #1; check({tag, " R9 protect"}, rd_data, DW'(m_prot));
        rd_slot = 1; #1; check({tag, " R9 update"}, rd_data, DW'(|m_pend));
        rd_slot = 5; #1; check("R9 unused glb", rd_data, '0);
        rd_glb = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin m_work[w][s] = 0; m_act[w][s] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_all("R1");
        // R2 / R8: fill every working slot
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) tick(1, 0, w, s, pat(w, s, 1), 0);
        check_all("R2");
        // R3: vsync without request
        tick(0, 0, 0, 0, 0, 1);
        check_all("R3");
        // R4: request then vsync
        tick(1, 1, 0, 1, 16'h1, 0);
        check_all("R4");
        tick(0, 0, 0, 0, 0, 1);
        check_all("R4");
        // R5: protect windows 1 and 2, rewrite everything
        tick(1, 1, 0, 0, 16'h6, 0);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) tick(1, 0, w, s, pat(w, s, 2), 0);
        tick(1, 1, 0, 1, 16'h1, 0);
        tick(0, 0, 0, 0, 0, 1);
        check_all("R5");
        tick(0, 0, 0, 0, 0, 1);
        check_all("R5");
        // R6: release protection
        tick(1, 1, 0, 0, 16'h0, 0);
        check_all("R6");
        tick(0, 0, 0, 0, 0, 1);
        check_all("R6");
        // R7: enable clear waits for vsync
        for (int w = 0; w < NW; w++) tick(1, 0, w, 0, 16'hFFFE, 0);
        check_all("R7");
        tick(1, 1, 0, 1, 16'h1, 0);
        tick(0, 0, 0, 0, 0, 1);
        check_all("R7");
        for (int w = 0; w < NW; w++) tick(1, 0, w, 0, 16'h0001, 0);
        tick(1, 1, 0, 1, 16'h1, 0);
        // R10: write in the same cycle as the load
        tick(1, 0, 2, 3, 16'hBEEF, 1);
        check_all("R10");
        // R10: request in the same cycle as vsync
        tick(1, 1, 0, 1, 16'h1, 1);
        check_all("R10");
        tick(0, 0, 0, 0, 0, 1);
        check_all("R10");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule